// File: doc/BRIEF.md
# Fault and Hiccup Restart Sequencer

This block supervises the start-up and fault recovery of a switching regulator controller. It samples six digital flags from external comparators: bias undervoltage, input undervoltage, over-temperature, overcurrent, output short circuit and enable. It then drives a digital soft-start ramp code, a driver-inhibit line, a compensation-clamp line, a power-good permission and a low-side-driver permission. The soft-start level is an unsigned counter that advances one code per prescaler tick. Fixed parameter codes stand for the regulation reference, the power-good threshold and the synchronous-rectifier threshold.

Every fault sends the block to an idle hiccup state. In that state the ramp is cleared, the drivers are inhibited and the compensation node is clamped for a timed interval before a restart is tried. Supply and thermal faults hold the block idle until they clear. Short-circuit and overcurrent faults do not hold it, so a persistent short produces one restart attempt per hiccup period. All timing counts prescaler ticks, so the hiccup and start-up intervals shrink for simulation by changing parameters. All pins are plain control and status levels. The block has no streamed data and therefore no valid/ready handshake.

Top module: `fault_hiccup_seq`

## Requirements
- R1: After reset, and for as long as synchronised enable is low, the state output is 0 (sleep), the driver-inhibit and clamp outputs are 1, and the ramp code, power-good permission and low-side permission are 0. Fault inputs have no effect in sleep.
- R2: Once enable has been high for the two synchronising cycles, the block enters state 1 (idle). It then stays there for STARTUP_TICKS*PRESCALE cycles before entering state 2 (soft-start).
- R3: In states 2 and 3 the ramp code rises by exactly one every PRESCALE cycles, starting from 0. It stops at 2^SS_W-1 and never wraps.
- R4: The block moves from state 2 to state 3 (run) once the ramp code reaches REF_CODE, and the ramp code is at least REF_CODE whenever the state is 3.
- R5: The power-good permission is 1 exactly when the state is 3 and the ramp code is at least PG_CODE.
- R6: The low-side permission is 1 exactly when the state is 2 or 3 and the ramp code is at least SYNC_CODE.
- R7: The ramp-select output is 1 exactly when the ramp code is below REF_CODE. It tells the external short-circuit comparator to measure against the ramp instead of the reference.
- R8: Any synchronised fault flag seen in state 2 or 3 moves the block to state 1 on the next clock edge. In that same cycle the ramp code is 0 and the driver-inhibit and clamp outputs are 1.
- R9: A hiccup entered from a fault lasts HICCUP_TICKS*PRESCALE cycles before the block returns to state 2, provided no supply or thermal fault is present.
- R10: While bias undervoltage, input undervoltage or over-temperature is asserted, the block does not leave state 1. It leaves within a few cycles after the flag clears, if the interval has already expired.
- R11: A short-circuit or overcurrent flag that stays high does not hold the block idle. Each hiccup interval ends with a restart into state 2, which the still-present flag immediately aborts.
- R12: A new rising edge of any fault flag while in state 1 restarts the hiccup interval from its full length.
- R13: Enable going low moves the block to state 0 from any state, taking precedence over all fault handling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Enable request |
| uv_bias_i | input | 1 | Bias-supply undervoltage flag |
| uv_in_i | input | 1 | Input-supply undervoltage flag |
| ot_i | input | 1 | Over-temperature flag |
| oc_i | input | 1 | Overcurrent flag |
| sc_i | input | 1 | Output short-circuit flag |
| ss_code_o | output | SS_W | Soft-start ramp code |
| drv_off_o | output | 1 | Both gate drivers inhibited |
| comp_clamp_o | output | 1 | Compensation node clamped low |
| pg_allow_o | output | 1 | Power-good output permitted |
| lowside_en_o | output | 1 | Low-side driver may switch synchronously |
| ramp_sel_o | output | 1 | Short comparator uses the ramp as its reference |
| state_o | output | 2 | Sequencer state: 0 sleep, 1 idle, 2 soft-start, 3 run |

## Verification
The bench holds a short circuit high across several hiccup periods. A design that treats the short as a hold fault would stick in idle, and one that skips the restart attempt would never show state 2. It releases supply and thermal faults both before and after the interval expires, which exposes a design that restarts while such a fault is present or that waits a second full interval after the release. It retriggers overcurrent halfway through a hiccup, so a design that ignores the new edge leaves idle about half an interval too early. It also runs the ramp into saturation, where a wrapping counter would drop back to 0 and withdraw power-good.

// File: rtl/seq_pkg.sv
package seq_pkg;

  typedef enum logic [1:0] {
    ST_SLEEP = 2'd0,
    ST_IDLE  = 2'd1,
    ST_RAMP  = 2'd2,
    ST_RUN   = 2'd3
  } seq_state_e;

  // fault vector bit positions
  localparam int FLT_N   = 5;
  localparam int FI_UVB  = 0;
  localparam int FI_UVI  = 1;
  localparam int FI_OT   = 2;
  localparam int FI_OC   = 3;
  localparam int FI_SC   = 4;

  // faults that must be gone before a restart
  localparam logic [FLT_N-1:0] HOLD_MASK =
    (FLT_N'(1) << FI_UVB) | (FLT_N'(1) << FI_UVI) | (FLT_N'(1) << FI_OT);

endpackage

// File: rtl/sync_stage.sv
module sync_stage #(
  parameter int N = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_bit
      logic meta_q, sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          meta_q <= 1'b0;
          sync_q <= 1'b0;
        end else begin
          meta_q <= d_i[g];
          sync_q <= meta_q;
        end
      end
      assign q_o[g] = sync_q;
    end
  endgenerate

endmodule

// File: rtl/tick_div.sv
module tick_div #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  output logic tick_o
);

  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (clr_i)      cnt_q <= '0;
    else if (tick_o)     cnt_q <= '0;
    else                 cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/ramp_gen.sv
module ramp_gen #(
  parameter int SS_W      = 8,
  parameter int REF_CODE  = 64,
  parameter int PG_CODE   = 128,
  parameter int SYNC_CODE = 136
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_i,
  input  logic            step_i,
  output logic [SS_W-1:0] code_o,
  output logic            at_ref_o,
  output logic            at_pg_o,
  output logic            at_sync_o
);

  localparam logic [SS_W-1:0] TOP   = {SS_W{1'b1}};
  localparam logic [SS_W-1:0] REF_C = SS_W'(REF_CODE);
  localparam logic [SS_W-1:0] PG_C  = SS_W'(PG_CODE);
  localparam logic [SS_W-1:0] SY_C  = SS_W'(SYNC_CODE);

  logic [SS_W-1:0] code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        code_q <= '0;
    else if (clr_i)                    code_q <= '0;
    else if (step_i && code_q != TOP)  code_q <= code_q + 1'b1;
  end

  assign code_o    = code_q;
  assign at_ref_o  = (code_q >= REF_C);
  assign at_pg_o   = (code_q >= PG_C);
  assign at_sync_o = (code_q >= SY_C);

  // R3: saturates at the top code, never wraps
  a_r3_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (code_q == TOP && !clr_i) |=> (code_q == TOP));

  // R3: moves by at most one code per cycle unless cleared
  a_r3_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> (code_q == $past(code_q) || code_q == $past(code_q) + 1'b1));

endmodule

// File: rtl/hiccup_fsm.sv
module hiccup_fsm
  import seq_pkg::*;
#(
  parameter int HICCUP_TICKS  = 750,
  parameter int STARTUP_TICKS = 200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_s_i,
  input  logic [FLT_N-1:0] flt_s_i,
  input  logic             tick_i,
  input  logic             at_ref_i,
  output seq_state_e       state_o,
  output logic             clr_div_o,
  output logic             clr_ramp_o,
  output logic             step_ramp_o
);

  localparam int MAXT = (HICCUP_TICKS > STARTUP_TICKS) ? HICCUP_TICKS : STARTUP_TICKS;
  localparam int TW   = $clog2(MAXT + 1);
  localparam logic [TW-1:0] T_HIC = TW'(HICCUP_TICKS);
  localparam logic [TW-1:0] T_STU = TW'(STARTUP_TICKS);

  seq_state_e       state_q, state_d;
  logic [TW-1:0]    timer_q, timer_d;
  logic [FLT_N-1:0] flt_d_q;
  logic [FLT_N-1:0] flt_rise;
  logic             any_flt, hold_flt;

  assign flt_rise = flt_s_i & ~flt_d_q;
  assign any_flt  = |flt_s_i;
  assign hold_flt = |(flt_s_i & HOLD_MASK);

  always_comb begin
    state_d   = state_q;
    timer_d   = timer_q;
    clr_div_o = 1'b0;
    if (!en_s_i) begin
      state_d = ST_SLEEP;
      timer_d = '0;
    end else begin
      unique case (state_q)
        ST_SLEEP: begin
          state_d   = ST_IDLE;
          timer_d   = T_STU;
          clr_div_o = 1'b1;
        end
        ST_IDLE: begin
          if (|flt_rise) begin
            timer_d   = T_HIC;
            clr_div_o = 1'b1;
          end else if (timer_q != '0) begin
            if (tick_i) timer_d = timer_q - 1'b1;
          end else if (!hold_flt) begin
            state_d   = ST_RAMP;
            clr_div_o = 1'b1;
          end
        end
        ST_RAMP, ST_RUN: begin
          if (any_flt) begin
            state_d   = ST_IDLE;
            timer_d   = T_HIC;
            clr_div_o = 1'b1;
          end else if (state_q == ST_RAMP && at_ref_i) begin
            state_d = ST_RUN;
          end
        end
        default: state_d = ST_SLEEP;
      endcase
    end
  end

  assign clr_ramp_o  = (state_d == ST_SLEEP) || (state_d == ST_IDLE);
  assign step_ramp_o = tick_i && !clr_ramp_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_SLEEP;
      timer_q <= '0;
      flt_d_q <= '0;
    end else begin
      state_q <= state_d;
      timer_q <= timer_d;
      flt_d_q <= flt_s_i;
    end
  end

  assign state_o = state_q;

  // R8: a fault during soft-start or run forces idle next cycle
  a_r8_fault_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_RAMP || state_q == ST_RUN) && any_flt && en_s_i)
      |=> (state_q == ST_IDLE));

  // R10: supply or thermal fault blocks the restart
  a_r10_hold_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && hold_flt) |=> (state_q != ST_RAMP));

  // R9: no restart before the interval has run out
  a_r9_no_early_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && timer_q > TW'(1)) |=> (state_q != ST_RAMP));

  // R13: enable low always leads to sleep
  a_r13_disable_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    !en_s_i |=> (state_q == ST_SLEEP));

endmodule

// File: rtl/fault_hiccup_seq.sv
module fault_hiccup_seq
  import seq_pkg::*;
#(
  parameter int PRESCALE      = 16,
  parameter int HICCUP_TICKS  = 750,
  parameter int STARTUP_TICKS = 200,
  parameter int SS_W          = 8,
  parameter int REF_CODE      = 64,
  parameter int PG_CODE       = 128,
  parameter int SYNC_CODE     = 136
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_i,
  input  logic            uv_bias_i,
  input  logic            uv_in_i,
  input  logic            ot_i,
  input  logic            oc_i,
  input  logic            sc_i,
  output logic [SS_W-1:0] ss_code_o,
  output logic            drv_off_o,
  output logic            comp_clamp_o,
  output logic            pg_allow_o,
  output logic            lowside_en_o,
  output logic            ramp_sel_o,
  output logic [1:0]      state_o
);

  localparam int SYN_N = FLT_N + 1;

  logic [SYN_N-1:0] raw, syn;
  logic [FLT_N-1:0] flt_s;
  logic             en_s;
  logic             tick, clr_div, clr_ramp, step_ramp;
  logic             at_ref, at_pg, at_sync;
  seq_state_e       state;

  always_comb begin
    raw         = '0;
    raw[FI_UVB] = uv_bias_i;
    raw[FI_UVI] = uv_in_i;
    raw[FI_OT]  = ot_i;
    raw[FI_OC]  = oc_i;
    raw[FI_SC]  = sc_i;
    raw[FLT_N]  = en_i;
  end

  sync_stage #(.N(SYN_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw), .q_o(syn)
  );

  assign flt_s = syn[FLT_N-1:0];
  assign en_s  = syn[FLT_N];

  tick_div #(.DIV(PRESCALE)) u_tick (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_div), .tick_o(tick)
  );

  hiccup_fsm #(
    .HICCUP_TICKS(HICCUP_TICKS),
    .STARTUP_TICKS(STARTUP_TICKS)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .en_s_i(en_s), .flt_s_i(flt_s),
    .tick_i(tick), .at_ref_i(at_ref), .state_o(state),
    .clr_div_o(clr_div), .clr_ramp_o(clr_ramp), .step_ramp_o(step_ramp)
  );

  ramp_gen #(
    .SS_W(SS_W), .REF_CODE(REF_CODE), .PG_CODE(PG_CODE), .SYNC_CODE(SYNC_CODE)
  ) u_ramp (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_ramp), .step_i(step_ramp),
    .code_o(ss_code_o), .at_ref_o(at_ref), .at_pg_o(at_pg), .at_sync_o(at_sync)
  );

  assign drv_off_o    = (state == ST_SLEEP) || (state == ST_IDLE);
  assign comp_clamp_o = drv_off_o;
  assign pg_allow_o   = (state == ST_RUN) && at_pg;
  assign lowside_en_o = !drv_off_o && at_sync;
  assign ramp_sel_o   = !at_ref;
  assign state_o      = state;

  // R1/R8: whenever drivers are inhibited the ramp sits at zero
  a_r1_off_ramp_zero: assert property (@(posedge clk) disable iff (!rst_n)
    drv_off_o |-> (ss_code_o == '0));

  // R4: run state only with the ramp at or above the reference code
  a_r4_run_above_ref: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN) |-> (ss_code_o >= SS_W'(REF_CODE)));

  // R5: power-good never granted below its threshold
  a_r5_pg_gated: assert property (@(posedge clk) disable iff (!rst_n)
    pg_allow_o |-> (ss_code_o >= SS_W'(PG_CODE)));

endmodule

// File: tb/test_fault_hiccup_seq.sv
module test_fault_hiccup_seq;

  localparam int CLK_P = 10;
  localparam int P     = 4;
  localparam int HT    = 20;
  localparam int ST    = 10;
  localparam int W     = 8;
  localparam int REFC  = 64;
  localparam int PGC   = 128;
  localparam int SYC   = 136;
  localparam int TOP   = 255;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic uvb = 1'b0, uvi = 1'b0, ot = 1'b0, oc = 1'b0, sc = 1'b0;
  logic [W-1:0] ss;
  logic drv_off, clamp, pg, lowside, rsel;
  logic [1:0] st;

  always #(CLK_P/2) clk = ~clk;

  fault_hiccup_seq #(
    .PRESCALE(P), .HICCUP_TICKS(HT), .STARTUP_TICKS(ST), .SS_W(W),
    .REF_CODE(REFC), .PG_CODE(PGC), .SYNC_CODE(SYC)
  ) i_fault_hiccup_seq (
    .clk(clk), .rst_n(rst_n), .en_i(en), .uv_bias_i(uvb), .uv_in_i(uvi),
    .ot_i(ot), .oc_i(oc), .sc_i(sc), .ss_code_o(ss), .drv_off_o(drv_off),
    .comp_clamp_o(clamp), .pg_allow_o(pg), .lowside_en_o(lowside),
    .ramp_sel_o(rsel), .state_o(st)
  );

  int n_vec = 0, n_bad = 0, cyc = 0;

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc > 150000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_st(input logic [1:0] s, input int maxc, output int n);
    n = 0;
    while (st != s && n < maxc) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic set_fault(input int k, input logic v);
    case (k)
      0: uvb = v;
      1: uvi = v;
      2: ot  = v;
      3: oc  = v;
      default: sc = v;
    endcase
  endtask

  function automatic bit is_hold(input int k);
    return k < 3;
  endfunction

  function automatic int exp_exit(input bit hold, input int rel);
    int base;
    base = HT * P + 1;
    if (hold && rel + 3 > base) return rel + 3;
    return base;
  endfunction

  initial begin
    int n, m, a, b, bad_pg, bad_ls, bad_rs;
    void'($urandom(32'd20240611));
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    chk(st == 2'd0, "R1 state", st, 0);
    chk(drv_off && clamp, "R1 drv_off/clamp", {drv_off, clamp}, 3);
    chk(ss == 0 && !pg && !lowside, "R1 ramp/pg/lowside", ss, 0);
    // R1 faults ignored while enable low
    for (int i = 0; i < 40; i++) begin
      set_fault($urandom_range(0, 4), 1'($urandom_range(0, 1)));
      step(1);
      if (i % 8 == 7) chk(st == 2'd0 && ss == 0, "R1 faults ignored in sleep", st, 0);
    end
    for (int k = 0; k < 5; k++) set_fault(k, 1'b0);
    step(4);

    // R2 start-up delay
    en = 1'b1;
    wait_st(2'd1, 10, n);
    chk(n <= 4 && st == 2'd1, "R2 idle entry", n, 3);
    wait_st(2'd2, ST * P + 20, n);
    chk(n >= ST * P - 2 && n <= ST * P + 3, "R2 startup length", n, ST * P + 1);
    chk(rsel && !lowside && !drv_off, "R7/R6 ramp start outputs", {rsel, lowside, drv_off}, 4);

    // R3 ramp rate
    a = ss;
    step(10 * P);
    b = ss;
    chk(b - a >= 9 && b - a <= 11, "R3 ramp rate", b - a, 10);

    // R4 run at reference
    wait_st(2'd3, REFC * P + 20, n);
    chk(st == 2'd3 && ss >= REFC && ss <= REFC + 1, "R4 run at ref code", ss, REFC);

    // R5 R6 R7 thresholds up to saturation
    bad_pg = 0; bad_ls = 0; bad_rs = 0;
    for (int i = 0; i < 300 * P && ss != TOP; i++) begin
      if (pg != (ss >= PGC)) bad_pg++;
      if (lowside != (ss >= SYC)) bad_ls++;
      if (rsel != (ss < REFC)) bad_rs++;
      step(1);
    end
    chk(bad_pg == 0, "R5 pg threshold", bad_pg, 0);
    chk(bad_ls == 0, "R6 lowside threshold", bad_ls, 0);
    chk(bad_rs == 0, "R7 ramp select", bad_rs, 0);
    step(30);
    chk(ss == TOP && pg, "R3 saturation no wrap", ss, TOP);

    // R8 / R11 persistent short
    sc = 1'b1;
    wait_st(2'd1, 6, n);
    chk(n <= 4 && st == 2'd1, "R8 short to idle", n, 3);
    chk(ss == 0 && drv_off && clamp && !pg, "R8 outputs on fault", ss, 0);
    for (int r = 0; r < 2; r++) begin
      wait_st(2'd2, HT * P + 20, n);
      chk(n >= HT * P - 1 && n <= HT * P + 3, "R11 restart each period", n, HT * P + 1);
      wait_st(2'd1, 6, n);
      chk(n <= 4 && st == 2'd1, "R11 restart aborted", n, 1);
    end
    sc = 1'b0;
    wait_st(2'd3, HT * P + REFC * P + 40, n);
    chk(st == 2'd3, "R9 recovers to run", st, 3);

    // R10 hold fault
    uvi = 1'b1;
    wait_st(2'd1, 6, n);
    step(HT * P + 30);
    chk(st == 2'd1, "R10 held idle by supply fault", st, 1);
    uvi = 1'b0;
    wait_st(2'd2, 8, n);
    chk(n <= 5 && st == 2'd2, "R10 restart after clear", n, 3);

    // R12 retrigger
    wait_st(2'd3, REFC * P + 20, n);
    oc = 1'b1;
    wait_st(2'd1, 6, n);
    oc = 1'b0;
    step(HT * P / 2);
    oc = 1'b1;
    step(2);
    oc = 1'b0;
    wait_st(2'd2, 2 * HT * P, n);
    chk(n >= HT * P - 2 && n <= HT * P + 5, "R12 interval restarted", n, HT * P + 2);

    // R13 enable low in run and in idle
    wait_st(2'd3, REFC * P + 20, n);
    en = 1'b0;
    wait_st(2'd0, 6, n);
    chk(n <= 4 && st == 2'd0 && drv_off, "R13 sleep from run", n, 3);
    en = 1'b1;
    sc = 1'b1;
    wait_st(2'd1, 6, n);
    step(5);
    en = 1'b0;
    wait_st(2'd0, 6, n);
    chk(n <= 4 && st == 2'd0, "R13 sleep overrides fault", n, 3);
    sc = 1'b0;
    step(4);

    // random fault kinds and release times
    en = 1'b1;
    for (int it = 0; it < 40; it++) begin
      int k, rel, tot;
      bit hold;
      wait_st(2'd2, ST * P + HT * P + 60, n);
      step($urandom_range(0, 400));
      chk(st == 2'd2 || st == 2'd3, "R3 active before fault", st, 3);
      k = $urandom_range(0, 4);
      hold = is_hold(k);
      set_fault(k, 1'b1);
      wait_st(2'd1, 6, n);
      chk(n <= 4 && ss == 0 && drv_off, "R8 random fault entry", n, 3);
      rel = hold ? $urandom_range(1, 2 * HT * P) : $urandom_range(1, HT * P - 10);
      step(rel);
      set_fault(k, 1'b0);
      wait_st(2'd2, 3 * HT * P, m);
      tot = rel + m;
      if (hold)
        chk(tot >= exp_exit(hold, rel) - 2 && tot <= exp_exit(hold, rel) + 3,
            "R10 random hold exit", tot, exp_exit(hold, rel));
      else
        chk(tot >= exp_exit(hold, rel) - 2 && tot <= exp_exit(hold, rel) + 3,
            "R9 random hiccup exit", tot, exp_exit(hold, rel));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule